// File: doc/BRIEF.md
# Banked Indexed Register Window

This block is the host-side register front end of a data-acquisition function. It puts a large internal byte array behind a small I/O window of sixteen byte offsets. A bank control bit decides what the four highest offsets of the window mean. With the bit clear, they reach the counter/timer registers that older drivers expect: three data bytes and one configuration byte. With the bit set, the same offsets become an index pointer and a 16-bit data port into the array. Each data-port access can move the pointer forward by itself, so a driver can stream through consecutive registers.

The host issues single-cycle read or write strobes. Each strobe carries a byte or word qualifier, a 4-bit byte offset and 16 bits of write data. A word access covers the even offset and the next one, and the low byte sits in bits 7:0. Read data is captured in the cycle of the read strobe and then held, so a status value cannot change while the host is still sampling it.

The counter registers are the same storage whether they are reached through the legacy offsets or through array indices 68 to 71. The array also holds three other registers:
- a general configuration byte, whose bit 0 stops the pointer from advancing;
- a scratch word;
- a fixed board identifier.

Everything resets to zero except the identifier. A driver that never touches the bank bit therefore sees only the legacy layout.

Top module: `bank_idx_window`

## Requirements
- R1: After reset, rdata_o is 0, the bank bit is 0, the pointer is 0, and the counter bytes, configuration byte and scratch word are all 0.
- R2: With the bank bit at 0, byte offsets 12, 13, 14 and 15 read and write counter data bytes 0, 1, 2 and the counter configuration byte. A word access at 12 returns data byte 0 in bits 7:0 and data byte 1 in bits 15:8.
- R3: Offset 11 holds the bank bit in data bit 0. A read of offset 11 returns 8'h00 or 8'h01.
- R4: With the bank bit at 1, offset 14 reads and writes the 8-bit pointer. Offset 15 reads 0 and ignores writes. Accesses at offset 14 never advance the pointer.
- R5: With the bank bit at 1, a byte access at offset 12 reaches array[ptr] and a byte access at offset 13 reaches array[ptr+1]. A word access at 12 reaches array[ptr] in bits 7:0 and array[ptr+1] in bits 15:8. Indices wrap modulo 256.
- R6: Each data-port read or write (bank bit 1, offsets 12 or 13) advances the pointer, modulo 256. A byte access adds 1 and a word access adds 2.
- R7: While bit 0 of the configuration byte at array index 0 is 1, data-port accesses leave the pointer unchanged. The test uses the value held before the access.
- R8: Array indices 68, 69, 70 and 71 share storage with counter data bytes 0, 1, 2 and the counter configuration byte.
- R9: Indices 248 and 249 form a read/write scratch word, low byte first. Indices 250 and 251 always read 8'h09 and 8'h10 (identifier 16'h1009), and writes to them are ignored. Any index not listed here reads 0 and ignores writes.
- R10: rdata_o changes only on the clock edge that samples a read strobe, taking the value addressed in that cycle. Writes and idle cycles leave it unchanged.
- R11: Offsets 0 to 10 read 0 and ignore writes. A word access ignores address bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| word_i | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| addr_i | input | 4 | Byte offset within the window |
| wdata_i | input | 16 | Write data, low byte in bits 7:0 |
| rdata_o | output | 16 | Captured read data |

## Verification
The assertions check on every cycle that:
- the pointer does not move while the bank bit is 0, or while advancing is inhibited and no pointer write occurs;
- the pointer steps by exactly 1 or 2 on a data-port access;
- the read data holds between read strobes;
- the scratch word holds when it is not written.

The aliasing between legacy offsets and array indices can only be shown by the bench's scenarios. The same is true of the wrap of the pointer and of word accesses from index 255 back to 0, of the read-only identifier, of writes that are ignored, and of the inhibit bit being applied from its pre-access value.

// File: rtl/bw_pkg.sv
package bw_pkg;
  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_BANK,
    TGT_ARR,
    TGT_PTR
  } tgt_e;

  localparam int unsigned OFF_BANK = 11;
  localparam int unsigned OFF_WIN  = 12;
  localparam int unsigned N_LANE   = 2;
endpackage

// File: rtl/bw_ptr.sv
module bw_ptr #(
  parameter int unsigned IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [IW-1:0] ld_val_i,
  input  logic          adv_i,
  input  logic          wide_i,
  output logic [IW-1:0] ptr_o
);
  logic [IW-1:0] step;
  assign step = wide_i ? IW'(2) : IW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (ld_i)  ptr_o <= ld_val_i;
    else if (adv_i) ptr_o <= ptr_o + step;
  end

  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !ld_i) |=> (ptr_o - $past(ptr_o)) == ($past(wide_i) ? IW'(2) : IW'(1))); // R6
endmodule

// File: rtl/bw_regfile.sv
module bw_regfile #(
  parameter int unsigned IW       = 8,
  parameter int unsigned NP       = 2,
  parameter int unsigned CFG_IDX  = 0,
  parameter int unsigned CTR_BASE = 68,
  parameter int unsigned N_CTR    = 4,
  parameter int unsigned SCR_IDX  = 248,
  parameter int unsigned ID_IDX   = 250,
  parameter logic [15:0] ID_VAL   = 16'h1009
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NP-1:0][IW-1:0]  idx_i,
  input  logic [NP-1:0]          we_i,
  input  logic [NP-1:0][7:0]     wd_i,
  output logic [NP-1:0][7:0]     rd_o,
  output logic                   aii_o
);
  logic [7:0] cfg_q;
  logic [7:0] ctr_q [N_CTR];
  logic [7:0] scr_q [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else
      for (int p = 0; p < NP; p++)
        if (we_i[p] && idx_i[p] == IW'(CFG_IDX)) cfg_q <= wd_i[p];
  end

  for (genvar g = 0; g < N_CTR; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctr_q[g] <= '0;
      else
        for (int p = 0; p < NP; p++)
          if (we_i[p] && idx_i[p] == IW'(CTR_BASE + g)) ctr_q[g] <= wd_i[p];
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) scr_q[g] <= '0;
      else
        for (int p = 0; p < NP; p++)
          if (we_i[p] && idx_i[p] == IW'(SCR_IDX + g)) scr_q[g] <= wd_i[p];
    end
  end

  function automatic logic [7:0] rd_byte(input logic [IW-1:0] idx);
    logic [7:0] v;
    v = '0;
    if (idx == IW'(CFG_IDX))     v = cfg_q;
    if (idx == IW'(SCR_IDX))     v = scr_q[0];
    if (idx == IW'(SCR_IDX + 1)) v = scr_q[1];
    if (idx == IW'(ID_IDX))      v = ID_VAL[7:0];
    if (idx == IW'(ID_IDX + 1))  v = ID_VAL[15:8];
    for (int c = 0; c < N_CTR; c++)
      if (idx == IW'(CTR_BASE + c)) v = ctr_q[c];
    return v;
  endfunction

  always_comb
    for (int p = 0; p < NP; p++) rd_o[p] = rd_byte(idx_i[p]);

  assign aii_o = cfg_q[0];

  AST_SCR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((we_i[0] && idx_i[0] == IW'(SCR_IDX)) || (we_i[1] && idx_i[1] == IW'(SCR_IDX)))
    |=> $stable(scr_q[0])); // R9
endmodule

// File: rtl/bw_rcap.sv
module bw_rcap #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end

  AST_RDATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(q_o)); // R10
endmodule

// File: rtl/bank_idx_window.sv
module bank_idx_window
  import bw_pkg::*;
#(
  parameter int unsigned AW       = 4,
  parameter int unsigned IW       = 8,
  parameter int unsigned CFG_IDX  = 0,
  parameter int unsigned CTR_BASE = 68,
  parameter int unsigned N_CTR    = 4,
  parameter int unsigned SCR_IDX  = 248,
  parameter int unsigned ID_IDX   = 250,
  parameter logic [15:0] ID_VAL   = 16'h1009
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          word_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  output logic [15:0]   rdata_o
);
  localparam int unsigned NL = N_LANE;

  logic                  bank_q;
  logic [IW-1:0]         ptr;
  logic                  aii;
  logic [AW-1:0]         base_off;
  logic [NL-1:0]         lane_en;
  logic [NL-1:0][IW-1:0] lane_idx;
  tgt_e [NL-1:0]         lane_tgt;
  logic [NL-1:0][7:0]    lane_wd;
  logic [NL-1:0][7:0]    lane_rd;
  logic [NL-1:0][7:0]    rf_rd;
  logic [NL-1:0]         rf_we;
  logic                  ptr_ld;
  logic                  ptr_adv;
  logic [15:0]           rd_word;

  // word accesses are aligned to the even offset
  assign base_off = word_i ? {addr_i[AW-1:1], 1'b0} : addr_i;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [AW-1:0] off;
    logic [1:0]    k;
    tgt_e          tgt;
    logic [IW-1:0] idx;
    logic [7:0]    rd;

    assign off = base_off + AW'(l);
    assign k   = 2'(off - AW'(OFF_WIN));

    always_comb begin
      tgt = TGT_NONE;
      idx = '0;
      if (off == AW'(OFF_BANK)) begin
        tgt = TGT_BANK;
      end else if (off >= AW'(OFF_WIN)) begin
        if (!bank_q) begin
          tgt = TGT_ARR;
          idx = IW'(CTR_BASE) + IW'(k);
        end else if (k < 2'd2) begin
          tgt = TGT_ARR;
          idx = ptr + IW'(k);
        end else if (k == 2'd2) begin
          tgt = TGT_PTR;
        end
      end
    end

    always_comb begin
      case (tgt)
        TGT_BANK: rd = {7'b0, bank_q};
        TGT_ARR:  rd = rf_rd[l];
        TGT_PTR:  rd = 8'(ptr);
        default:  rd = '0;
      endcase
    end

    assign lane_en[l]  = (l == 0) ? 1'b1 : word_i;
    assign lane_tgt[l] = tgt;
    assign lane_idx[l] = idx;
    assign lane_rd[l]  = rd;
    assign lane_wd[l]  = wdata_i[8*l +: 8];
    assign rf_we[l]    = wr_i && lane_en[l] && (tgt == TGT_ARR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_q <= 1'b0;
    else
      for (int l = 0; l < NL; l++)
        if (wr_i && lane_en[l] && lane_tgt[l] == TGT_BANK) bank_q <= lane_wd[l][0];
  end

  bw_regfile #(
    .IW(IW), .NP(NL), .CFG_IDX(CFG_IDX), .CTR_BASE(CTR_BASE), .N_CTR(N_CTR),
    .SCR_IDX(SCR_IDX), .ID_IDX(ID_IDX), .ID_VAL(ID_VAL)
  ) u_rf (
    .clk_i, .rst_ni,
    .idx_i (lane_idx),
    .we_i  (rf_we),
    .wd_i  (lane_wd),
    .rd_o  (rf_rd),
    .aii_o (aii)
  );

  // only lane 0 can land on the pointer or start a data-port access
  assign ptr_ld  = wr_i && lane_tgt[0] == TGT_PTR;
  assign ptr_adv = bank_q && (rd_i || wr_i) && lane_tgt[0] == TGT_ARR && !aii;

  bw_ptr #(.IW(IW)) u_ptr (
    .clk_i, .rst_ni,
    .ld_i     (ptr_ld),
    .ld_val_i (IW'(lane_wd[0])),
    .adv_i    (ptr_adv),
    .wide_i   (word_i),
    .ptr_o    (ptr)
  );

  assign rd_word = {lane_en[1] ? lane_rd[1] : 8'h00, lane_rd[0]};

  bw_rcap #(.DW(16)) u_rcap (
    .clk_i, .rst_ni,
    .cap_i (rd_i),
    .d_i   (rd_word),
    .q_o   (rdata_o)
  );

  AST_LEGACY_NO_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bank_q |=> $stable(ptr)); // R2

  AST_AII_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aii && !ptr_ld) |=> $stable(ptr)); // R7

  AST_PTR_ACCESS_NO_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_q && rd_i && base_off == AW'(OFF_WIN + 2)) |=> $stable(ptr)); // R4
endmodule

// File: tb/bank_idx_window_bench.sv
module bank_idx_window_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_i = 1'b0, wr_i = 1'b0, word_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;

  int total = 0, bad = 0;
  bit done = 0;

  bit         m_bank;
  logic [7:0] m_ptr;
  logic [7:0] m_mem [256];
  logic [15:0] m_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_idx_window u_bank_idx_window (
    .clk_i(clk), .rst_ni, .rd_i, .wr_i, .word_i, .addr_i, .wdata_i, .rdata_o
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_arr_rd(input logic [7:0] idx);
    if (idx == 8'd250) return 8'h09;
    if (idx == 8'd251) return 8'h10;
    return m_mem[idx];
  endfunction

  function automatic void m_arr_wr(input logic [7:0] idx, input logic [7:0] v);
    if (idx == 8'd0 || (idx >= 8'd68 && idx <= 8'd71) || idx == 8'd248 || idx == 8'd249)
      m_mem[idx] = v;
  endfunction

  function automatic logic [7:0] m_off_rd(input logic [3:0] off);
    if (off == 4'd11) return {7'b0, m_bank};
    if (off < 4'd12) return 8'h00;
    if (!m_bank) return m_arr_rd(8'd68 + 8'(off - 4'd12));
    if (off == 4'd12 || off == 4'd13) return m_arr_rd(m_ptr + 8'(off - 4'd12));
    if (off == 4'd14) return m_ptr;
    return 8'h00;
  endfunction

  function automatic void m_off_wr(input logic [3:0] off, input logic [7:0] v);
    if (off == 4'd11) m_bank = v[0];
    else if (off >= 4'd12) begin
      if (!m_bank) m_arr_wr(8'd68 + 8'(off - 4'd12), v);
      else if (off == 4'd12 || off == 4'd13) m_arr_wr(m_ptr + 8'(off - 4'd12), v);
      else if (off == 4'd14) m_ptr = v;
    end
  endfunction

  // one access: drive the port, update the model, compare on reads
  task automatic acc(input string tag, input bit w, input bit wd16,
                     input logic [3:0] a, input logic [15:0] d);
    logic [3:0]  base;
    logic [15:0] exp;
    bit          adv;
    base = wd16 ? {a[3:1], 1'b0} : a;
    adv  = m_bank && (base == 4'd12 || base == 4'd13) && !m_arr_rd(8'd0)[0];
    exp  = {wd16 ? m_off_rd(base + 4'd1) : 8'h00, m_off_rd(base)};
    if (w) begin
      m_off_wr(base, d[7:0]);
      if (wd16) m_off_wr(base + 4'd1, d[15:8]);
    end
    if (adv) m_ptr = m_ptr + (wd16 ? 8'd2 : 8'd1);
    @(negedge clk);
    rd_i = !w; wr_i = w; word_i = wd16; addr_i = a; wdata_i = d;
    @(negedge clk);
    rd_i = 0; wr_i = 0;
    if (!w) begin
      m_last = exp;
      chk(tag, rdata_o, exp);
    end else begin
      chk({tag, " hold R10"}, rdata_o, m_last);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    m_bank = 0; m_ptr = 0; m_last = 0;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    chk("R1 rdata reset", rdata_o, 16'h0000);
    acc("R1 bank reset", 0, 0, 4'd11, 0);
    acc("R1 ctr word reset", 0, 1, 4'd12, 0);
    acc("R1 ctr word hi reset", 0, 1, 4'd14, 0);

    acc("R2 wr ct0", 1, 0, 4'd12, 16'h00a1);
    acc("R2 wr ct1", 1, 0, 4'd13, 16'h00b2);
    acc("R2 wr ct2/cfg", 1, 1, 4'd14, 16'hd4c3);
    acc("R2 rd ct1", 0, 0, 4'd13, 0);
    chk("R2 ct1 literal", rdata_o, 16'h00b2);
    acc("R2 rd word12", 0, 1, 4'd12, 0);
    chk("R2 word literal", rdata_o, 16'hb2a1);
    acc("R2 rd cfg", 0, 0, 4'd15, 0);

    acc("R11 wr off3", 1, 1, 4'd2, 16'hffff);
    acc("R11 rd off3", 0, 0, 4'd3, 0);
    acc("R11 odd word", 0, 1, 4'd13, 0);
    chk("R11 odd word literal", rdata_o, 16'hb2a1);

    acc("R3 set bank", 1, 0, 4'd11, 16'h00ff);
    acc("R3 rd bank", 0, 0, 4'd11, 0);
    chk("R3 literal", rdata_o, 16'h0001);

    acc("R4 wr ptr", 1, 0, 4'd14, 16'h0045);
    acc("R4 rd ptr", 0, 0, 4'd14, 0);
    acc("R4 rd ptr again", 0, 0, 4'd14, 0);
    chk("R4 ptr literal", rdata_o, 16'h0045);
    acc("R4 wr off15", 1, 0, 4'd15, 16'h00ee);
    acc("R4 rd off15", 0, 0, 4'd15, 0);
    acc("R8 rd idx69 byte", 0, 0, 4'd12, 0);
    chk("R8 ct1 via array", rdata_o, 16'h00b2);
    acc("R6 ptr after byte", 0, 0, 4'd14, 0);
    chk("R6 ptr literal", rdata_o, 16'h0046);

    acc("R8 ptr68", 1, 0, 4'd14, 16'h0044);
    acc("R8 wr word68", 1, 1, 4'd12, 16'h2211);
    acc("R6 ptr word step", 0, 0, 4'd14, 0);
    chk("R6 word step literal", rdata_o, 16'h0046);
    acc("R8 bank0", 1, 0, 4'd11, 16'h0000);
    acc("R8 rd legacy", 0, 1, 4'd12, 0);
    chk("R8 alias literal", rdata_o, 16'h2211);
    acc("R8 bank1", 1, 0, 4'd11, 16'h0001);

    acc("R9 ptr248", 1, 0, 4'd14, 16'h00f8);
    acc("R9 wr scr", 1, 1, 4'd12, 16'hbeef);
    acc("R9 wr id", 1, 1, 4'd12, 16'h5555);
    acc("R9 ptr248 again", 1, 0, 4'd14, 16'h00f8);
    acc("R9 rd scr", 0, 1, 4'd12, 0);
    chk("R9 scr literal", rdata_o, 16'hbeef);
    acc("R9 rd id", 0, 1, 4'd12, 0);
    chk("R9 id literal", rdata_o, 16'h1009);
    acc("R5 rd off13 byte", 0, 0, 4'd13, 0);
    acc("R9 ptr100", 1, 0, 4'd14, 16'h0064);
    acc("R9 wr unimpl", 1, 0, 4'd12, 16'h00aa);
    acc("R9 ptr100 again", 1, 0, 4'd14, 16'h0064);
    acc("R9 rd unimpl", 0, 0, 4'd12, 0);

    acc("R5 ptr255", 1, 0, 4'd14, 16'h00ff);
    acc("R5 wrap word rd", 0, 1, 4'd12, 0);
    acc("R6 wrap ptr", 0, 0, 4'd14, 0);
    chk("R6 wrap literal", rdata_o, 16'h0001);

    acc("R7 ptr0", 1, 0, 4'd14, 16'h0000);
    acc("R7 set aii", 1, 0, 4'd12, 16'h0001);
    acc("R7 ptr adv pre", 0, 0, 4'd14, 0);
    chk("R7 pre-value literal", rdata_o, 16'h0001);
    acc("R7 ptr248", 1, 0, 4'd14, 16'h00f8);
    acc("R7 rd1", 0, 1, 4'd12, 0);
    acc("R7 rd2", 0, 0, 4'd13, 0);
    acc("R7 ptr held", 0, 0, 4'd14, 0);
    chk("R7 held literal", rdata_o, 16'h00f8);
    acc("R7 ptr0 clr", 1, 0, 4'd14, 16'h0000);
    acc("R7 clr aii", 1, 0, 4'd12, 16'h0000);
    acc("R7 ptr after clr", 0, 0, 4'd14, 0);
    chk("R7 clr literal", rdata_o, 16'h0000);

    for (int n = 0; n < 3000; n++) begin
      int unsigned sel;
      logic [3:0]  a;
      logic [15:0] d;
      sel = $urandom_range(0, 99);
      d = 16'($urandom);
      a = 4'($urandom_range(10, 15));
      if ($urandom_range(0, 19) == 0) a = 4'($urandom_range(0, 15));
      if (sel < 8) begin
        acc("R3 rnd bank", 1, 0, 4'd11, {15'b0, d[0]});
      end else if (sel < 20) begin
        logic [7:0] p;
        case ($urandom_range(0, 3))
          0: p = 8'($urandom_range(66, 72));
          1: p = 8'($urandom_range(246, 255));
          2: p = 8'($urandom_range(0, 2));
          default: p = 8'($urandom);
        endcase
        acc("R4 rnd ptr", 1, 0, 4'd14, {8'h00, p});
      end else if (sel < 24) begin
        // configuration byte at index 0, inhibit set rarely
        acc("R4 rnd ptr0", 1, 0, 4'd14, 16'h0000);
        acc("R7 rnd cfg", 1, 0, 4'd12, {8'h00, 7'(d[7:1]), (d[3:0] == 4'h0)});
      end else if (sel < 60) begin
        acc("R5 R6 rnd rd", 0, $urandom_range(0, 1) == 1, a, 0);
      end else begin
        acc("R5 R8 rnd wr", 1, $urandom_range(0, 1) == 1, a, d);
      end
    end

    acc("R10 final rd", 0, 0, 4'd11, 0);
    repeat (3) @(negedge clk);
    chk("R10 idle hold", rdata_o, m_last);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule